// File: doc/BRIEF.md
# Interrupt Source Qualification and Routing

This block sits at the front of an interrupt controller. It holds two registers for each of a small set of interrupt sources: a control word (mask, delivery mode, polarity, sense, priority, vector and a read-only activity flag) and a destination word that selects CPUs. Each raw source input is first corrected for polarity. It is then turned into a pending state, which either follows a level or latches an assertion edge. On every cycle the block picks the lowest-numbered source that qualifies for delivery. It then offers that source's index on one or more per-CPU offer ports.

A source in directed mode is offered to every CPU its destination word selects. A source in distributed mode goes to one CPU. The choice rotates round-robin over the selected CPUs, starting after the CPU that source last served. A delivered source sets its activity flag and stays silent until that flag is cleared. The flag is cleared either by a release strobe from the downstream acknowledge logic or, for level sources, by the level going away. The offers are single-cycle strobes with no back-pressure: a CPU port that cannot take an offer is expected to rely on the source's activity flag, which remains set until released.

Top module: `irq_src_router`

## Requirements
- R1: After reset every control word reads 0x80000000 (masked, edge, active-low, priority 0, vector 0), every destination word reads 0x00000001 (CPU 0 only), the last-served CPU of every source is CPU 0, and no offer is driven.
- R2: Control word fields: bit 31 mask, bit 30 activity (read-only), bit 29 mode (1 = distributed), bit 23 polarity, bit 22 sense (1 = level), bits 19:16 priority, bits 7:0 vector. A write stores only the bits in 0xA0CF00FF and leaves activity unchanged. All other bits read as zero.
- R3: A destination word write keeps bits 31:30 and the low NCPU bits (CPU select, bit c = CPU c). All other bits read as zero.
- R4: Source s occupies byte address s*32. The control word is at offset 0 and the destination word at offset 16. Any address with bits 3:0 non-zero reads zero and ignores writes. Reads are combinational and writes take effect at the clock edge while reg_we is high.
- R5: Polarity 1 treats a high input as asserted. Polarity 0 treats a low input as asserted.
- R6: With level sense, pending equals the asserted state sampled at the previous clock edge. A level source whose input is deasserted has its activity cleared at that edge. A level source that is still held after a release is offered again.
- R7: With edge sense, a rising asserted state sets pending, and delivery clears it. An edge that arrives while the source is active stays pending and is offered once the activity is released.
- R8: A source is offered only if it is pending, unmasked, has non-zero priority, has activity clear and has a non-zero CPU select. Making a stalled source qualify by a register write leads to an offer one cycle after the write edge.
- R9: Delivery sets the source's activity bit (readable at bit 30). A cycle with rel_valid high clears the activity of source rel_src.
- R10: At most one source is delivered per cycle, and the lowest index wins. An input asserted before clock edge k gives an offer strobe that is valid for exactly the cycle after edge k+1.
- R11: In directed mode (bit 29 = 0) the source is offered, with its index, on every CPU port whose select bit is set.
- R12: In distributed mode the search starts at the CPU after the last-served CPU and wraps at NCPU. Exactly one offer goes to the first selected CPU found, and that CPU becomes the new last-served CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Raw interrupt source inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NSRC)+5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rel_valid | input | 1 | Activity release strobe |
| rel_src | input | $clog2(NSRC) | Source whose activity is released |
| offer_valid | output | NCPU | Per-CPU offer strobe |
| offer_src | output | NCPU*$clog2(NSRC) | Per-CPU offered source index, CPU c at bits [c*W +: W] |

## Verification
The hardest situation to reach is a distributed source whose round-robin pointer has moved away from CPU 0. It only moves after a delivery, and a delivery blocks further offers until the activity is released. The stimulus therefore repeats a cycle of pulse, check and release on one distributed source, and it expects the CPU to alternate each time. A second case that needs care is an edge arriving while the source is active. The bench pulses a source that is already active, confirms that no offer follows, and then releases the source to expose the held pending state.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;

  localparam logic [31:0] CTRL_WMASK = 32'hA0CF_00FF;

  typedef struct packed {
    logic              msk;
    logic              mode;
    logic              pol;
    logic              lvl;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{msk: 1'b1, mode: 1'b0, pol: 1'b0, lvl: 1'b0,
                                   prio: '0, vec: '0};
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_src_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NCPU = 2,
  localparam int SIDX_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int ADDR_W = SIDX_W + 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NSRC-1:0]            act_set,
  input  logic [NSRC-1:0]            act_clr,
  output ctrl_t [NSRC-1:0]           ctrl_o,
  output logic [NSRC-1:0][NCPU-1:0]  dest_o,
  output logic [NSRC-1:0]            act_o
);
  logic [SIDX_W-1:0] sidx;
  logic              sel_dest;
  logic              addr_ok;
  logic [NSRC-1:0][1:0] crit_q;

  assign sidx     = reg_addr[ADDR_W-1:5];
  assign sel_dest = reg_addr[4];
  assign addr_ok  = (reg_addr[3:0] == 4'd0) && (int'(sidx) < NSRC);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic hit;
    assign hit = reg_we && addr_ok && (sidx == SIDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_o[s] <= CTRL_RESET;
        dest_o[s] <= NCPU'(1);
        crit_q[s] <= 2'b00;
      end else if (hit && !sel_dest) begin
        ctrl_o[s] <= '{msk: reg_wdata[31], mode: reg_wdata[29], pol: reg_wdata[23],
                       lvl: reg_wdata[22], prio: reg_wdata[19:16], vec: reg_wdata[7:0]};
      end else if (hit && sel_dest) begin
        dest_o[s] <= reg_wdata[NCPU-1:0];
        crit_q[s] <= reg_wdata[31:30];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          act_o[s] <= 1'b0;
      else if (act_clr[s]) act_o[s] <= 1'b0;
      else if (act_set[s]) act_o[s] <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (addr_ok) begin
      if (sel_dest) begin
        reg_rdata[31:30]     = crit_q[sidx];
        reg_rdata[NCPU-1:0]  = dest_o[sidx];
      end else begin
        reg_rdata[31]    = ctrl_o[sidx].msk;
        reg_rdata[30]    = act_o[sidx];
        reg_rdata[29]    = ctrl_o[sidx].mode;
        reg_rdata[23]    = ctrl_o[sidx].pol;
        reg_rdata[22]    = ctrl_o[sidx].lvl;
        reg_rdata[19:16] = ctrl_o[sidx].prio;
        reg_rdata[7:0]   = ctrl_o[sidx].vec;
      end
    end
  end
endmodule

// File: rtl/irq_src_sense.sv
module irq_src_sense
  import irq_src_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  ctrl_t [NSRC-1:0] ctrl,
  input  logic [NSRC-1:0] consume,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] low_o
);
  for (genvar s = 0; s < NSRC; s++) begin : g_sense
    logic asrt;
    logic prev_q;

    assign asrt     = ctrl[s].pol ? src_in[s] : ~src_in[s];
    assign low_o[s] = ctrl[s].lvl & ~asrt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q    <= 1'b1;
        pend_o[s] <= 1'b0;
      end else begin
        prev_q <= asrt;
        if (ctrl[s].lvl) pend_o[s] <= asrt;
        else             pend_o[s] <= (pend_o[s] & ~consume[s]) | (asrt & ~prev_q);
      end
    end
  end
endmodule

// File: rtl/irq_src_route.sv
module irq_src_route
  import irq_src_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NCPU = 2,
  localparam int SIDX_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            pend,
  input  ctrl_t [NSRC-1:0]           ctrl,
  input  logic [NSRC-1:0][NCPU-1:0]  dest,
  input  logic [NSRC-1:0]            act,
  output logic [NSRC-1:0]            deliver_o,
  output logic [NCPU-1:0]            offer_valid_o,
  output logic [NCPU*SIDX_W-1:0]     offer_src_o
);
  logic [NSRC-1:0]            elig;
  logic                       any;
  logic [SIDX_W-1:0]          sel;
  logic [NCPU-1:0]            tgt;
  logic [CPU_W-1:0]           nlast;
  logic [NSRC-1:0][CPU_W-1:0] last_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    assign elig[s] = pend[s] & ~ctrl[s].msk & (ctrl[s].prio != '0) & ~act[s] & (|dest[s]);
  end

  always_comb begin
    any = |elig;
    sel = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (elig[s]) sel = SIDX_W'(s);
    end
    deliver_o = '0;
    if (any) deliver_o[sel] = 1'b1;
  end

  always_comb begin
    logic found;
    int   c;
    found = 1'b0;
    nlast = last_q[sel];
    tgt   = '0;
    c     = 0;
    if (!ctrl[sel].mode) begin
      tgt = dest[sel];
    end else begin
      for (int k = 1; k <= NCPU; k++) begin
        c = int'(last_q[sel]) + k;
        if (c >= NCPU) c = c - NCPU;
        if (!found && dest[sel][c]) begin
          found  = 1'b1;
          tgt[c] = 1'b1;
          nlast  = CPU_W'(c);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offer_valid_o <= '0;
      offer_src_o   <= '0;
      last_q        <= '0;
    end else begin
      offer_valid_o <= any ? tgt : '0;
      for (int c = 0; c < NCPU; c++) offer_src_o[c*SIDX_W +: SIDX_W] <= sel;
      if (any && ctrl[sel].mode) last_q[sel] <= nlast;
    end
  end
endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
  import irq_src_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NCPU = 2,
  localparam int SIDX_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int ADDR_W = SIDX_W + 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src_in,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic                   rel_valid,
  input  logic [SIDX_W-1:0]      rel_src,
  output logic [NCPU-1:0]        offer_valid,
  output logic [NCPU*SIDX_W-1:0] offer_src
);
  ctrl_t [NSRC-1:0]           ctrl;
  logic [NSRC-1:0][NCPU-1:0]  dest;
  logic [NSRC-1:0]            act;
  logic [NSRC-1:0]            pend;
  logic [NSRC-1:0]            low;
  logic [NSRC-1:0]            deliver;
  logic [NSRC-1:0]            rel_oh;
  logic [NSRC-1:0]            act_clr;

  always_comb begin
    rel_oh = '0;
    if (rel_valid) rel_oh[rel_src] = 1'b1;
  end
  assign act_clr = rel_oh | low;

  irq_src_regs #(.NSRC(NSRC), .NCPU(NCPU)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_set(deliver),
    .act_clr(act_clr), .ctrl_o(ctrl), .dest_o(dest), .act_o(act)
  );

  irq_src_sense #(.NSRC(NSRC)) sense_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .ctrl(ctrl),
    .consume(deliver), .pend_o(pend), .low_o(low)
  );

  irq_src_route #(.NSRC(NSRC), .NCPU(NCPU)) route_i (
    .clk(clk), .rst_n(rst_n), .pend(pend), .ctrl(ctrl), .dest(dest),
    .act(act), .deliver_o(deliver), .offer_valid_o(offer_valid),
    .offer_src_o(offer_src)
  );
endmodule

// File: rtl/irq_src_router_chk.sv
module irq_src_router_chk
  import irq_src_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NCPU = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NSRC-1:0]           deliver,
  input logic [NSRC-1:0]           act,
  input logic [NSRC-1:0]           act_clr,
  input logic [NSRC-1:0]           low,
  input ctrl_t [NSRC-1:0]          ctrl,
  input logic [NSRC-1:0][NCPU-1:0] dest,
  input logic [NCPU-1:0]           offer_valid
);
  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    // R9: delivery leaves the source active unless cleared that cycle
    a_r9_act_after_deliver: assert property (@(posedge clk) disable iff (!rst_n)
      deliver[s] && !act_clr[s] |=> act[s]);
    // R6: a deasserted level source is not active one edge later
    a_r6_level_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      low[s] |=> !act[s]);
    // R12: distributed delivery yields exactly one offer
    a_r12_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      deliver[s] && ctrl[s].mode |=> $onehot(offer_valid));
    // R11: offers stay within the selected CPUs and at least one is made
    a_r11_within_dest: assert property (@(posedge clk) disable iff (!rst_n)
      deliver[s] |=> ((offer_valid & ~$past(dest[s])) == '0) && (offer_valid != '0));
  end
endmodule

bind irq_src_router irq_src_router_chk #(.NSRC(NSRC), .NCPU(NCPU)) chk_i (
  .clk(clk), .rst_n(rst_n), .deliver(deliver), .act(act), .act_clr(act_clr),
  .low(low), .ctrl(ctrl), .dest(dest), .offer_valid(offer_valid)
);

// File: tb/irq_src_router_tb_top.sv
module irq_src_router_tb_top;
  localparam int NSRC = 16;
  localparam int NCPU = 2;
  localparam int SW   = 4;
  localparam int AW   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic rel_valid = 1'b0;
  logic [SW-1:0] rel_src = '0;
  logic [NCPU-1:0] offer_valid;
  logic [NCPU*SW-1:0] offer_src;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_src_router #(.NSRC(NSRC), .NCPU(NCPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rel_valid(rel_valid), .rel_src(rel_src), .offer_valid(offer_valid),
    .offer_src(offer_src)
  );

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic chk_offer(input string req, input logic [NCPU-1:0] exp_v, input int s);
    chk(req, 32'(offer_valid), 32'(exp_v));
    for (int c = 0; c < NCPU; c++)
      if (exp_v[c]) chk(req, 32'(offer_src[c*SW +: SW]), 32'(s));
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input logic [31:0] exp_v);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 chk(req, reg_rdata, exp_v);
  endtask

  task automatic cfg(input int s, input logic [31:0] ctrl, input logic [31:0] dst);
    wr(s*32 + 16, dst);
    wr(s*32, ctrl);
  endtask

  // pulse high for one edge; returns at the negedge where the offer shows
  task automatic pulse(input int s);
    @(negedge clk); src_in[s] = 1'b1;
    @(negedge clk); src_in[s] = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_src(input int s);
    @(negedge clk); rel_valid = 1'b1; rel_src = SW'(s);
    @(negedge clk); rel_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1 chk("R1 offer", 32'(offer_valid), 32'h0);
    rd("R1 ctrl0", 0, 32'h8000_0000);
    rd("R1 dest15", 15*32 + 16, 32'h0000_0001);
  endtask

  task automatic t_regs;
    wr(2*32, 32'hFFFF_FFFF);
    rd("R2 ctrl mask", 2*32, 32'hA0CF_00FF);
    wr(2*32, 32'h8000_0000);
    wr(2*32 + 16, 32'hFFFF_FFFF);
    rd("R3 dest mask", 2*32 + 16, 32'hC000_0003);
    wr(2*32 + 16, 32'h0000_0001);
    wr(1*32 + 4, 32'hFFFF_FFFF);
    rd("R4 odd offset reads 0", 1*32 + 4, 32'h0);
    rd("R4 write ignored", 1*32, 32'h8000_0000);
  endtask

  task automatic t_level_low;
    @(negedge clk); src_in[3] = 1'b1;
    cfg(3, 32'h0043_0033, 32'h1);
    @(negedge clk);
    chk_offer("R5 inactive-high no offer", 2'b00, 3);
    src_in[3] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk_offer("R5 R10 active-low offer", 2'b01, 3);
    @(negedge clk);
    chk_offer("R10 single-cycle strobe", 2'b00, 3);
    rd("R9 activity set", 3*32, 32'h4043_0033);
    release_src(3);
    chk_offer("R6 held level reoffered", 2'b01, 3);
    @(negedge clk); src_in[3] = 1'b1;
    @(negedge clk);
    rd("R6 level drop clears activity", 3*32, 32'h0043_0033);
  endtask

  task automatic t_edge;
    cfg(5, 32'h0082_0055, 32'h2);
    pulse(5);
    chk_offer("R7 edge offer CPU1", 2'b10, 5);
    @(negedge clk);
    chk_offer("R10 strobe ends", 2'b00, 5);
    rd("R9 activity after edge", 5*32, 32'h4082_0055);
    pulse(5);
    chk_offer("R7 edge while active held", 2'b00, 5);
    release_src(5);
    chk_offer("R7 R9 held edge after release", 2'b10, 5);
  endtask

  task automatic t_qualify;
    cfg(6, 32'h0080_0066, 32'h1);
    pulse(6);
    chk_offer("R8 zero priority blocks", 2'b00, 6);
    wr(6*32, 32'h0084_0066);
    @(negedge clk);
    chk_offer("R8 priority write releases", 2'b01, 6);
    cfg(7, 32'h0081_0077, 32'h0);
    pulse(7);
    chk_offer("R8 empty dest blocks", 2'b00, 7);
    wr(7*32 + 16, 32'h1);
    @(negedge clk);
    chk_offer("R8 dest write releases", 2'b01, 7);
    wr(8*32, 32'h8081_0088);
    pulse(8);
    chk_offer("R8 masked blocks", 2'b00, 8);
  endtask

  task automatic t_lowest;
    cfg(9, 32'h0081_0099, 32'h1);
    cfg(10, 32'h0081_00AA, 32'h1);
    @(negedge clk); src_in[9] = 1'b1; src_in[10] = 1'b1;
    @(negedge clk); src_in[9] = 1'b0; src_in[10] = 1'b0;
    @(negedge clk);
    chk_offer("R10 lowest index first", 2'b01, 9);
    @(negedge clk);
    chk_offer("R10 next index follows", 2'b01, 10);
  endtask

  task automatic t_directed;
    cfg(11, 32'h0081_00BB, 32'h3);
    pulse(11);
    chk_offer("R11 directed both CPUs", 2'b11, 11);
    release_src(11);
    pulse(11);
    chk_offer("R11 directed again both", 2'b11, 11);
  endtask

  task automatic t_distributed;
    cfg(12, 32'h2081_00CC, 32'h3);
    pulse(12);
    chk_offer("R12 first goes to CPU1", 2'b10, 12);
    release_src(12);
    pulse(12);
    chk_offer("R12 wraps to CPU0", 2'b01, 12);
    release_src(12);
    pulse(12);
    chk_offer("R12 back to CPU1", 2'b10, 12);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_level_low();
    t_edge();
    t_qualify();
    t_lowest();
    t_directed();
    t_distributed();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule